// File: doc/BRIEF.md
# Pin Pulse-Width Capture Channel

This block is one timer channel that watches a single external input pin and measures time between pin transitions in clock cycles. The pin is resynchronised to the block clock, and its rising and falling transitions are found. A programmable edge code then turns those transitions into start events and capture events. A start event clears a counter and starts it. A capture event latches the counter value and presents it on a one-cycle strobe.

Software sets the channel up through one 16-bit mode word. That word holds the edge code, the start-trigger source and a 4-bit operating mode. Two kinds of measurement are available. The single-edge codes measure the period between successive edges of one polarity. The two paired codes measure how long the pin stays low, or how long it stays high. Captured values leave as a plain strobe with data. There is no ready signal and no back-pressure: the consumer must take the value in the cycle it is offered, because the next capture overwrites it.

Top module: `pin_width_capture`

## Requirements
- R1: After reset the mode word reads 0000h, overflow is 0, and no start or capture strobe is produced while the pin is quiet.
- R2: The mode word keeps bits 15:14, 12, 10:8 (start source), 7:6 (edge code) and 3:0 (operating mode). Bits 13, 5 and 4 always read 0. On a channel built as channel zero (the default), bit 11 reads 0 and writes to it are lost. With no write, the read value does not change.
- R3: Edge code 00 makes the falling edge valid. The first falling edge starts the count. Each later falling edge captures the clocks since the previous falling edge and restarts the count.
- R4: Edge code 01 behaves as R3 but on rising edges.
- R5: Edge code 10 measures low time: a falling edge starts the count and a rising edge captures it. The captured value equals the number of clocks the pin was low.
- R6: Edge code 11 with start source 010 measures high time: a rising edge starts the count and a falling edge captures it.
- R7: Edge code 11 with any start source other than 010 behaves exactly as code 10.
- R8: In low-time or high-time measurement, a capture edge with no start edge before it is ignored. After a capture, no further capture happens until a new start edge arrives.
- R9: A start strobe or a capture strobe lasts one cycle. It appears on the third rising clock edge after the pin changes: two cycles of synchroniser plus the registered strobe.
- R10: The counter stops at FFFFh. Once it is there and another cycle passes without an event, overflow goes to 1 and stays at 1 (a capture taken then reads FFFFh) until the next start edge clears it.
- R11: An operating mode of 0000 disables the channel: no strobes are produced, and the counter, the armed state and overflow are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_i | input | 1 | Raw external input pin, asynchronous to clk |
| mode_we_i | input | 1 | Write enable for the mode word |
| mode_wdata_i | input | 16 | Mode word write data |
| mode_rdata_o | output | 16 | Current mode word, with fixed-zero bits applied |
| start_evt_o | output | 1 | One-cycle strobe: a start edge was taken |
| cap_valid_o | output | 1 | One-cycle strobe: cap_value_o holds a new capture |
| cap_value_o | output | 16 | Clock count latched by the last capture |
| overflow_o | output | 1 | Sticky flag: the counter reached its limit without a capture |

## Verification
Every pin-driven result is due on the third rising edge after the bench changes the pin. The bench changes the pin on a falling edge. A monitor on falling edges records the cycle number and the value of each strobe. Each task then compares the recorded cycle with the change cycle plus three, and the value with the difference between the two change cycles, so a one-cycle shift in latency or in count is reported. A mode write is read back one edge after it is applied. Overflow is sampled a few cycles before and a few cycles after the 65535-cycle point.

// File: rtl/pwc_pkg.sv
`timescale 1ns/1ps
package pwc_pkg;

  localparam int MODE_W = 16;

  // Positions in the mode word
  localparam int ES_LSB  = 6;   // edge code, 2 bits
  localparam int SRC_LSB = 8;   // start source, 3 bits
  localparam int MD_LSB  = 0;   // operating mode, 4 bits
  localparam int LOCK_BIT = 11; // read-only zero on channel zero

  localparam logic [2:0] SRC_PIN = 3'b010;

  typedef enum logic [1:0] {
    EDGE_FALL   = 2'b00,
    EDGE_RISE   = 2'b01,
    EDGE_LOW_W  = 2'b10,
    EDGE_HIGH_W = 2'b11
  } edge_code_e;

  typedef struct packed {
    edge_code_e  edge_code;
    logic [2:0]  start_src;
    logic [3:0]  op_mode;
  } chan_cfg_t;

endpackage

// File: rtl/pwc_pin_sync.sv
`timescale 1ns/1ps
module pwc_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] shreg;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg  <= '0;
      last_q <= 1'b0;
    end else begin
      shreg  <= {shreg[STAGES-2:0], pin_i};
      last_q <= shreg[STAGES-1];
    end
  end

  assign rise_o = shreg[STAGES-1] & ~last_q;
  assign fall_o = ~shreg[STAGES-1] & last_q;

  AST_RISE_FROM_PIN: assert property (@(posedge clk) disable iff (rst)
    rise_o |-> $past(pin_i, STAGES)) else $error("rise without pin high"); // R9
  AST_FALL_FROM_PIN: assert property (@(posedge clk) disable iff (rst)
    fall_o |-> !$past(pin_i, STAGES)) else $error("fall without pin low"); // R9

endmodule

// File: rtl/pwc_mode_reg.sv
`timescale 1ns/1ps
module pwc_mode_reg
  import pwc_pkg::*;
#(
  parameter bit IS_CHAN_ZERO = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_i,
  input  logic [MODE_W-1:0] wdata_i,
  output logic [MODE_W-1:0] rdata_o,
  output chan_cfg_t         cfg_o
);
  localparam logic [MODE_W-1:0] BASE_MASK = 16'hDFCF;
  localparam logic [MODE_W-1:0] LOCK_MASK = MODE_W'(1) << LOCK_BIT;

  logic [MODE_W-1:0] keep_mask;
  logic [MODE_W-1:0] word_q;

  generate
    if (IS_CHAN_ZERO) begin : g_chan0
      assign keep_mask = BASE_MASK & ~LOCK_MASK;
    end else begin : g_chanx
      assign keep_mask = BASE_MASK;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)       word_q <= '0;
    else if (we_i) word_q <= wdata_i & keep_mask;
  end

  assign rdata_o          = word_q;
  assign cfg_o.edge_code  = edge_code_e'(word_q[ES_LSB +: 2]);
  assign cfg_o.start_src  = word_q[SRC_LSB +: 3];
  assign cfg_o.op_mode    = word_q[MD_LSB +: 4];

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !we_i |=> $stable(rdata_o)) else $error("mode word moved without write"); // R2

endmodule

// File: rtl/pwc_trig_decode.sv
`timescale 1ns/1ps
module pwc_trig_decode
  import pwc_pkg::*;
(
  input  chan_cfg_t cfg_i,
  input  logic      rise_i,
  input  logic      fall_i,
  output logic      enable_o,
  output logic      width_mode_o,
  output logic      start_hit_o,
  output logic      cap_hit_o
);
  edge_code_e eff_code;

  always_comb begin
    enable_o = (cfg_i.op_mode != 4'd0);
    // paired high-time code only honoured with pin-edge start source
    if (cfg_i.edge_code == EDGE_HIGH_W && cfg_i.start_src != SRC_PIN)
      eff_code = EDGE_LOW_W;
    else
      eff_code = cfg_i.edge_code;

    width_mode_o = eff_code[1];
    unique case (eff_code)
      EDGE_FALL:   begin start_hit_o = fall_i; cap_hit_o = fall_i; end
      EDGE_RISE:   begin start_hit_o = rise_i; cap_hit_o = rise_i; end
      EDGE_LOW_W:  begin start_hit_o = fall_i; cap_hit_o = rise_i; end
      default:     begin start_hit_o = rise_i; cap_hit_o = fall_i; end
    endcase
  end

endmodule

// File: rtl/pwc_measure.sv
`timescale 1ns/1ps
module pwc_measure #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable_i,
  input  logic             width_mode_i,
  input  logic             start_hit_i,
  input  logic             cap_hit_i,
  output logic             start_evt_o,
  output logic             cap_valid_o,
  output logic [CNT_W-1:0] cap_value_o,
  output logic             overflow_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic             armed_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q     <= 1'b0;
      cnt_q       <= '0;
      overflow_o  <= 1'b0;
      start_evt_o <= 1'b0;
      cap_valid_o <= 1'b0;
      cap_value_o <= '0;
    end else if (!enable_i) begin
      armed_q     <= 1'b0;
      cnt_q       <= '0;
      overflow_o  <= 1'b0;
      start_evt_o <= 1'b0;
      cap_valid_o <= 1'b0;
    end else begin
      start_evt_o <= 1'b0;
      cap_valid_o <= 1'b0;
      if (start_hit_i) begin
        start_evt_o <= 1'b1;
        overflow_o  <= 1'b0;
        cnt_q       <= CNT_ONE;
        armed_q     <= 1'b1;
        if (!width_mode_i && armed_q) begin
          cap_valid_o <= 1'b1;
          cap_value_o <= cnt_q;
        end
      end else if (width_mode_i && cap_hit_i && armed_q) begin
        cap_valid_o <= 1'b1;
        cap_value_o <= cnt_q;
        armed_q     <= 1'b0;
      end else if (armed_q) begin
        if (cnt_q == CNT_MAX) overflow_o <= 1'b1;
        else                  cnt_q      <= cnt_q + CNT_ONE;
      end
    end
  end

  AST_CAP_NEEDS_ARM: assert property (@(posedge clk) disable iff (rst)
    cap_valid_o |-> $past(armed_q)) else $error("capture while idle"); // R8
  AST_CAP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    cap_valid_o |=> !cap_valid_o) else $error("capture strobe too long"); // R9
  AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (rst)
    (enable_i && armed_q && cnt_q == CNT_MAX && !start_hit_i && !cap_hit_i)
      |=> (cnt_q == CNT_MAX && overflow_o)) else $error("counter wrapped"); // R10

endmodule

// File: rtl/pin_width_capture.sv
`timescale 1ns/1ps
module pin_width_capture
  import pwc_pkg::*;
#(
  parameter int CNT_W        = 16,
  parameter int SYNC_STAGES  = 2,
  parameter bit IS_CHAN_ZERO = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pin_i,
  input  logic              mode_we_i,
  input  logic [MODE_W-1:0] mode_wdata_i,
  output logic [MODE_W-1:0] mode_rdata_o,
  output logic              start_evt_o,
  output logic              cap_valid_o,
  output logic [CNT_W-1:0]  cap_value_o,
  output logic              overflow_o
);
  chan_cfg_t cfg;
  logic rise, fall;
  logic enable, width_mode, start_hit, cap_hit;

  pwc_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin_i(pin_i), .rise_o(rise), .fall_o(fall)
  );

  pwc_mode_reg #(.IS_CHAN_ZERO(IS_CHAN_ZERO)) u_mode (
    .clk(clk), .rst(rst), .we_i(mode_we_i), .wdata_i(mode_wdata_i),
    .rdata_o(mode_rdata_o), .cfg_o(cfg)
  );

  pwc_trig_decode u_dec (
    .cfg_i(cfg), .rise_i(rise), .fall_i(fall), .enable_o(enable),
    .width_mode_o(width_mode), .start_hit_o(start_hit), .cap_hit_o(cap_hit)
  );

  pwc_measure #(.CNT_W(CNT_W)) u_meas (
    .clk(clk), .rst(rst), .enable_i(enable), .width_mode_i(width_mode),
    .start_hit_i(start_hit), .cap_hit_i(cap_hit), .start_evt_o(start_evt_o),
    .cap_valid_o(cap_valid_o), .cap_value_o(cap_value_o), .overflow_o(overflow_o)
  );

endmodule

// File: tb/pin_width_capture_test.sv
`timescale 1ns/1ps
module pin_width_capture_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pin = 1'b0;
  logic        we = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        start_evt, cap_valid, ovf;
  logic [15:0] cap_value;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int n_cap = 0, n_start = 0, cap_cyc = -1, start_cyc = -1;
  logic [15:0] cap_last = '0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pin_width_capture uut (
    .clk(clk), .rst(rst), .pin_i(pin), .mode_we_i(we), .mode_wdata_i(wdata),
    .mode_rdata_o(rdata), .start_evt_o(start_evt), .cap_valid_o(cap_valid),
    .cap_value_o(cap_value), .overflow_o(ovf)
  );

  always @(negedge clk) begin
    if (cap_valid) begin n_cap++; cap_last = cap_value; cap_cyc = cyc; end
    if (start_evt) begin n_start++; start_cyc = cyc; end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_pin(input logic v, output int at);
    @(negedge clk);
    pin = v;
    at = cyc;
  endtask

  task automatic wr_mode(input logic [15:0] d);
    @(negedge clk); we = 1'b1; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  function automatic logic [15:0] mword(input logic [1:0] es, input logic [2:0] src);
    return {5'b0, src, es, 2'b00, 4'h4};
  endfunction

  task automatic cfg(input logic [1:0] es, input logic [2:0] src, input logic lvl);
    pin = lvl;
    idle(6);
    wr_mode(16'h0000);
    wr_mode(mword(es, src));
    idle(2);
    n_cap = 0; n_start = 0; cap_cyc = -1; start_cyc = -1;
  endtask

  task automatic t_reset;
    chk(rdata == 16'h0000, "R1 mode after reset", rdata, 0);
    chk(ovf == 1'b0, "R1 overflow after reset", ovf, 0);
    idle(5);
    chk(n_cap == 0 && n_start == 0, "R1 no strobes", n_cap + n_start, 0);
  endtask

  task automatic t_mode_reg;
    wr_mode(16'hFFFF);
    chk(rdata == 16'hD7CF, "R2 fixed-zero bits", rdata, 16'hD7CF);
    idle(3);
    chk(rdata == 16'hD7CF, "R2 hold without write", rdata, 16'hD7CF);
    wr_mode(16'h0A85);
    chk(rdata == 16'h0285, "R2 bit11 locked on channel zero", rdata, 16'h0285);
  endtask

  task automatic t_low_width;
    int c0, c1;
    cfg(2'b10, 3'b010, 1'b1);
    set_pin(1'b0, c0);
    idle(6);
    set_pin(1'b1, c1);
    idle(6);
    chk(n_start == 1, "R5 one start", n_start, 1);
    chk(start_cyc == c0 + 3, "R9 start latency", start_cyc, c0 + 3);
    chk(n_cap == 1, "R5 one capture", n_cap, 1);
    chk(cap_cyc == c1 + 3, "R9 capture latency", cap_cyc, c1 + 3);
    chk(cap_last == 16'(c1 - c0), "R5 low time", cap_last, c1 - c0);
  endtask

  task automatic t_high_width;
    int c0, c1;
    cfg(2'b11, 3'b010, 1'b0);
    set_pin(1'b1, c0);
    idle(11);
    set_pin(1'b0, c1);
    idle(6);
    chk(n_cap == 1, "R6 one capture", n_cap, 1);
    chk(cap_last == 16'(c1 - c0), "R6 high time", cap_last, c1 - c0);
  endtask

  task automatic t_fold;
    int c0, c1, c2;
    cfg(2'b11, 3'b000, 1'b0);
    set_pin(1'b1, c0);
    idle(4);
    chk(n_cap == 0 && n_start == 0, "R7 rise not a start", n_cap + n_start, 0);
    set_pin(1'b0, c1);
    idle(8);
    set_pin(1'b1, c2);
    idle(6);
    chk(n_start == 1, "R7 fall starts", n_start, 1);
    chk(n_cap == 1 && cap_last == 16'(c2 - c1), "R7 low time measured", cap_last, c2 - c1);
  endtask

  task automatic t_ignore;
    int c0, c1, c2, c3, c4;
    cfg(2'b10, 3'b010, 1'b0);
    set_pin(1'b1, c0);
    idle(8);
    chk(n_cap == 0, "R8 capture before start ignored", n_cap, 0);
    set_pin(1'b0, c1);
    idle(4);
    set_pin(1'b1, c2);
    idle(20);
    chk(n_cap == 1 && cap_last == 16'(c2 - c1), "R8 first width", cap_last, c2 - c1);
    chk(ovf == 1'b0, "R8 idle after capture", ovf, 0);
    set_pin(1'b0, c3);
    idle(3);
    set_pin(1'b1, c4);
    idle(6);
    chk(n_cap == 2 && cap_last == 16'(c4 - c3), "R8 fresh start", cap_last, c4 - c3);
  endtask

  task automatic t_fall_period;
    int c0, c1, c2;
    cfg(2'b00, 3'b010, 1'b1);
    set_pin(1'b0, c0);
    idle(2);
    set_pin(1'b1, c1);
    idle(6);
    chk(n_cap == 0 && n_start == 1, "R3 first fall only starts", n_cap, 0);
    set_pin(1'b0, c2);
    idle(6);
    chk(n_cap == 1 && cap_last == 16'(c2 - c0), "R3 fall period", cap_last, c2 - c0);
    chk(n_start == 2, "R3 restart on capture", n_start, 2);
  endtask

  task automatic t_rise_period;
    int c0, c1, c2;
    cfg(2'b01, 3'b010, 1'b0);
    set_pin(1'b1, c0);
    idle(3);
    set_pin(1'b0, c1);
    idle(2);
    set_pin(1'b1, c2);
    idle(6);
    chk(n_cap == 1 && cap_last == 16'(c2 - c0), "R4 rise period", cap_last, c2 - c0);
    chk(cap_cyc == c2 + 3, "R4 capture latency", cap_cyc, c2 + 3);
  endtask

  task automatic t_disabled;
    int c0, c1;
    cfg(2'b10, 3'b010, 1'b1);
    wr_mode({5'b0, 3'b010, 2'b10, 2'b00, 4'h0});
    set_pin(1'b0, c0);
    idle(5);
    set_pin(1'b1, c1);
    idle(6);
    chk(n_cap == 0 && n_start == 0, "R11 no strobes when off", n_cap + n_start, 0);
    chk(ovf == 1'b0, "R11 overflow clear when off", ovf, 0);
  endtask

  task automatic t_saturate;
    int c0, c1, c2;
    cfg(2'b11, 3'b010, 1'b0);
    set_pin(1'b1, c0);
    idle(65500);
    chk(ovf == 1'b0, "R10 no overflow before limit", ovf, 0);
    idle(45);
    chk(ovf == 1'b1, "R10 overflow at limit", ovf, 1);
    set_pin(1'b0, c1);
    idle(6);
    chk(n_cap == 1 && cap_last == 16'hFFFF, "R10 saturated capture", cap_last, 16'hFFFF);
    chk(ovf == 1'b1, "R10 overflow sticky", ovf, 1);
    set_pin(1'b1, c2);
    idle(6);
    chk(ovf == 1'b0, "R10 cleared by start", ovf, 0);
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    idle(4);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_mode_reg();
    t_low_width();
    t_high_width();
    t_fold();
    t_ignore();
    t_fall_period();
    t_rise_period();
    t_disabled();
    t_saturate();
    finish_up();
  end

endmodule